// File: doc/BRIEF.md
# PC-Indexed Stride Prediction Table

This block watches the stream of memory accesses made by load and store instructions and learns, separately for each instruction, the distance between that instruction's successive addresses. The instruction address selects an entry in a direct-mapped table. Each entry holds a tag taken from the upper instruction-address bits, the address of the previous access, the last stride seen and a small saturating confidence counter. Because every instruction has its own entry, several strided streams that are interleaved in time are each followed on their own.

On every accepted access the block subtracts the stored address from the new one to get a fresh stride. It raises or lowers the confidence count depending on whether the fresh stride matches the stored one. When the stride was confirmed and confidence is high enough, it requests a prefetch one stride ahead of the current address. The request is registered and shows up on the output the cycle after the access. Queuing of requests and any cache interaction are left to the surrounding logic.

Top module: `stride_rpt`

## Requirements
- R1: While `rst_ni` is low and after it rises, every table entry is invalid and `pf_valid_o` is 0.
- R2: An access whose entry is invalid or whose tag differs is a miss. The entry is rewritten with the new tag, the current address as last address, stride 0 and count 0, and no prefetch is issued for it.
- R3: On a hit whose fresh stride (current address minus last address, modulo 2^ADDR_W) equals the stored stride, the count goes up by one and saturates at 2^CNT_W-1 (3 by default).
- R4: A prefetch is issued for a hit only if the strides match, the updated count is greater than THRESH (default 1, so at least 2), and the stride is non-zero. The prefetch address is the current address plus the stride. A fresh instruction with a steady stride therefore first prefetches on its fourth access.
- R5: On a hit whose fresh stride differs from the stored one, the stored stride is replaced by the fresh stride and no prefetch is issued. The count is lowered by one, stopping at 0, when MISMATCH_POLICY is POL_DECREMENT (the default). It is cleared to 0 when MISMATCH_POLICY is POL_CLEAR.
- R6: A stride of zero never produces a prefetch, however often it repeats.
- R7: Strides are two's-complement, so a steadily decreasing address stream is predicted in the downward direction.
- R8: Accesses from instructions that map to different entries do not disturb each other's training, even when they are interleaved cycle by cycle.
- R9: Two instructions with the same index bits (PC bits [PC_LSB+IDX_W-1:PC_LSB]) but different tags evict each other, and the evicted instruction starts training again from a miss.
- R10: `pf_valid_o` is 0 in any cycle that follows a clock edge at which `acc_valid_i` was low.
- R11: The prefetch produced by an access appears on `pf_valid_o` and `pf_addr_o` exactly one clock cycle after that access is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_pc_i | input | PC_W | Instruction address of the access |
| acc_addr_i | input | ADDR_W | Data address of the access |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_addr_o | output | ADDR_W | Prefetch request address |

## Verification
A single instruction is trained with a steady positive stride. This shows the exact access on which prefetching starts and that it keeps going once the count is saturated. The stride of that instruction is then changed, with the decrement and the clear policy side by side in two instances. The two show different recovery lengths, one access versus two, which separates the two mismatch rules. Repeated identical addresses, a falling address stream, three instructions interleaved cycle by cycle, and two instructions sharing an index each test something different: the zero-stride block, signed arithmetic, per-entry isolation, and replacement on a tag conflict.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic {
    POL_DECREMENT = 1'b0,
    POL_CLEAR     = 1'b1
  } mis_pol_e;
endpackage

// File: rtl/rpt_index_split.sv
module rpt_index_split #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 4,
  localparam int TAG_W = PC_W - PC_LSB - IDX_W
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  assign idx_o = pc_i[PC_LSB +: IDX_W];
  assign tag_o = pc_i[PC_W-1 -: TAG_W];

  generate
    if (PC_LSB > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^pc_i[PC_LSB-1:0];
    end
  endgenerate
endmodule

// File: rtl/rpt_entry_array.sv
module rpt_entry_array #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [ADDR_W-1:0] rd_last_o,
  output logic [ADDR_W-1:0] rd_stride_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_last_i,
  input  logic [ADDR_W-1:0] wr_stride_i,
  input  logic [CNT_W-1:0]  wr_cnt_i
);
  logic              vld_q    [ENTRIES];
  logic [TAG_W-1:0]  tag_q    [ENTRIES];
  logic [ADDR_W-1:0] last_q   [ENTRIES];
  logic [ADDR_W-1:0] stride_q [ENTRIES];
  logic [CNT_W-1:0]  cnt_q    [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i]    <= 1'b0;
        tag_q[i]    <= '0;
        last_q[i]   <= '0;
        stride_q[i] <= '0;
        cnt_q[i]    <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
        vld_q[i]    <= 1'b1;
        tag_q[i]    <= wr_tag_i;
        last_q[i]   <= wr_last_i;
        stride_q[i] <= wr_stride_i;
        cnt_q[i]    <= wr_cnt_i;
      end
    end
  end

  assign rd_vld_o    = vld_q[rd_idx_i];
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_last_o   = last_q[rd_idx_i];
  assign rd_stride_o = stride_q[rd_idx_i];
  assign rd_cnt_o    = cnt_q[rd_idx_i];

  // Entry written on an access owns its slot next cycle (replacement)
  p_write_owns_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vld_q[$past(wr_idx_i)] && (tag_q[$past(wr_idx_i)] == $past(wr_tag_i))));
endmodule

// File: rtl/rpt_stride_calc.sv
module rpt_stride_calc
  import rpt_pkg::*;
#(
  parameter int       TAG_W           = 26,
  parameter int       ADDR_W          = 32,
  parameter int       CNT_W           = 2,
  parameter int       THRESH          = 1,
  parameter mis_pol_e MISMATCH_POLICY = POL_DECREMENT
) (
  input  logic              acc_valid_i,
  input  logic [TAG_W-1:0]  acc_tag_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              ent_vld_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [ADDR_W-1:0] ent_last_i,
  input  logic [ADDR_W-1:0] ent_stride_i,
  input  logic [CNT_W-1:0]  ent_cnt_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] stride_next_o,
  output logic [CNT_W-1:0]  cnt_next_o,
  output logic              pf_fire_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] THR     = CNT_W'(THRESH);

  logic [ADDR_W-1:0] new_stride;
  logic              match;

  assign hit_o      = acc_valid_i && ent_vld_i && (ent_tag_i == acc_tag_i);
  // modulo subtraction gives the two's-complement stride
  assign new_stride = acc_addr_i - ent_last_i;
  assign match      = (new_stride == ent_stride_i);

  always_comb begin
    if (!hit_o) begin
      stride_next_o = '0;
      cnt_next_o    = '0;
    end else if (match) begin
      stride_next_o = ent_stride_i;
      cnt_next_o    = (ent_cnt_i == CNT_MAX) ? CNT_MAX : ent_cnt_i + 1'b1;
    end else begin
      stride_next_o = new_stride;
      if (MISMATCH_POLICY == POL_CLEAR) cnt_next_o = '0;
      else cnt_next_o = (ent_cnt_i == '0) ? '0 : ent_cnt_i - 1'b1;
    end
  end

  assign pf_fire_o = hit_o && match && (ent_stride_i != '0) && (cnt_next_o > THR);
  assign pf_addr_o = acc_addr_i + ent_stride_i;
endmodule

// File: rtl/stride_rpt.sv
module stride_rpt
  import rpt_pkg::*;
#(
  parameter int       PC_W            = 32,
  parameter int       ADDR_W          = 32,
  parameter int       ENTRIES         = 16,
  parameter int       PC_LSB          = 2,
  parameter int       CNT_W           = 2,
  parameter int       THRESH          = 1,
  parameter mis_pol_e MISMATCH_POLICY = POL_DECREMENT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [PC_W-1:0]   acc_pc_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - PC_LSB - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              ent_vld;
  logic [TAG_W-1:0]  ent_tag;
  logic [ADDR_W-1:0] ent_last, ent_stride, stride_next, pf_addr_d;
  logic [CNT_W-1:0]  ent_cnt, cnt_next;
  logic              hit, pf_fire;

  rpt_index_split #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W)) u_split (
    .pc_i (acc_pc_i),
    .idx_o(idx),
    .tag_o(tag)
  );

  rpt_entry_array #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (idx),
    .rd_vld_o   (ent_vld),
    .rd_tag_o   (ent_tag),
    .rd_last_o  (ent_last),
    .rd_stride_o(ent_stride),
    .rd_cnt_o   (ent_cnt),
    .wr_en_i    (acc_valid_i),
    .wr_idx_i   (idx),
    .wr_tag_i   (tag),
    .wr_last_i  (acc_addr_i),
    .wr_stride_i(stride_next),
    .wr_cnt_i   (cnt_next)
  );

  rpt_stride_calc #(
    .TAG_W(TAG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .THRESH(THRESH), .MISMATCH_POLICY(MISMATCH_POLICY)
  ) u_calc (
    .acc_valid_i  (acc_valid_i),
    .acc_tag_i    (tag),
    .acc_addr_i   (acc_addr_i),
    .ent_vld_i    (ent_vld),
    .ent_tag_i    (ent_tag),
    .ent_last_i   (ent_last),
    .ent_stride_i (ent_stride),
    .ent_cnt_i    (ent_cnt),
    .hit_o        (hit),
    .stride_next_o(stride_next),
    .cnt_next_o   (cnt_next),
    .pf_fire_o    (pf_fire),
    .pf_addr_o    (pf_addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_valid_o <= 1'b0;
      pf_addr_o  <= '0;
    end else begin
      pf_valid_o <= pf_fire;
      if (pf_fire) pf_addr_o <= pf_addr_d;
    end
  end

  p_pf_follows_access_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> $past(acc_valid_i));
  p_idle_no_pf_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(acc_valid_i) |-> !pf_valid_o);
  p_miss_no_pf_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !hit) |=> !pf_valid_o);
  p_nonzero_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (pf_addr_o != $past(acc_addr_i)));
endmodule

// File: tb/stride_rpt_tb.sv
module stride_rpt_tb;
  import rpt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_pc = '0, acc_addr = '0;
  logic        pf_v, pf_vc;
  logic [31:0] pf_a, pf_ac;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  stride_rpt u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(acc_valid), .acc_pc_i(acc_pc),
    .acc_addr_i(acc_addr), .pf_valid_o(pf_v), .pf_addr_o(pf_a)
  );

  stride_rpt #(.MISMATCH_POLICY(POL_CLEAR)) u_dut_clr (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(acc_valid), .acc_pc_i(acc_pc),
    .acc_addr_i(acc_addr), .pf_valid_o(pf_vc), .pf_addr_o(pf_ac)
  );

  task automatic chk(input string req, input logic gv, input logic [31:0] ga,
                     input logic ev, input logic [31:0] ea);
    n_chk++;
    if (gv !== ev || (ev && ga !== ea)) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h", req, gv, ga, ev, ea);
    end
  endtask

  // one access; outputs sampled at the next falling edge
  task automatic step(input string req, input logic [31:0] pc, input logic [31:0] addr,
                      input logic ev, input logic [31:0] ea,
                      input logic evc, input logic [31:0] eac);
    acc_valid = 1'b1; acc_pc = pc; acc_addr = addr;
    @(negedge clk);
    acc_valid = 1'b0;
    chk({req, " (decrement)"}, pf_v, pf_a, ev, ea);
    chk({req, " (clear)"}, pf_vc, pf_ac, evc, eac);
  endtask

  task automatic idle(input string req);
    acc_valid = 1'b0;
    @(negedge clk);
    chk({req, " (decrement)"}, pf_v, pf_a, 1'b0, '0);
    chk({req, " (clear)"}, pf_vc, pf_ac, 1'b0, '0);
  endtask

  localparam logic [31:0] PC_A = 32'h100, PC_C = 32'h500; // both index 0, tags differ
  localparam logic [31:0] A0 = 32'h1000, S1 = 32'h40, S2 = 32'h80;
  logic [31:0] b0;

  task automatic t_reset();
    chk("R1 reset", pf_v, pf_a, 1'b0, '0);
    chk("R1 reset clr", pf_vc, pf_ac, 1'b0, '0);
  endtask

  task automatic t_train();
    step("R2 first access miss", PC_A, A0, 1'b0, '0, 1'b0, '0);
    step("R5 stride learnt", PC_A, A0 + S1, 1'b0, '0, 1'b0, '0);
    step("R4 count 1 below threshold", PC_A, A0 + 2*S1, 1'b0, '0, 1'b0, '0);
    for (int k = 3; k < 8; k++)
      step("R4 R11 R3 confirmed stride prefetch", PC_A, A0 + k*S1,
           1'b1, A0 + (k+1)*S1, 1'b1, A0 + (k+1)*S1);
  endtask

  task automatic t_mismatch();
    b0 = A0 + 7*S1 + S2;
    step("R5 mismatch no prefetch", PC_A, b0, 1'b0, '0, 1'b0, '0);
    step("R5 decrement recovers in one", PC_A, b0 + S2, 1'b1, b0 + 2*S2, 1'b0, '0);
    step("R5 clear recovers in two", PC_A, b0 + 2*S2, 1'b1, b0 + 3*S2, 1'b1, b0 + 3*S2);
  endtask

  task automatic t_zero();
    for (int k = 0; k < 6; k++)
      step("R6 zero stride", 32'h204, 32'h7700, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic t_negative();
    for (int k = 0; k < 3; k++)
      step("R7 negative warmup", 32'h308, 32'h8000 - k*32'h20, 1'b0, '0, 1'b0, '0);
    step("R7 negative prefetch", 32'h308, 32'h8000 - 3*32'h20,
         1'b1, 32'h8000 - 4*32'h20, 1'b1, 32'h8000 - 4*32'h20);
  endtask

  task automatic t_interleave();
    logic [31:0] pcs [3];
    logic [31:0] bas [3];
    logic [31:0] sts [3];
    pcs[0] = 32'h40C; bas[0] = 32'h2000; sts[0] = 32'h8;
    pcs[1] = 32'h410; bas[1] = 32'h3000; sts[1] = 32'h100;
    pcs[2] = 32'h414; bas[2] = 32'h4000; sts[2] = 32'hFFFF_FFFC;
    for (int r = 0; r < 5; r++)
      for (int j = 0; j < 3; j++)
        step("R8 interleaved streams", pcs[j], bas[j] + r*sts[j],
             r >= 3, bas[j] + (r+1)*sts[j], r >= 3, bas[j] + (r+1)*sts[j]);
  endtask

  task automatic t_conflict();
    step("R9 conflicting tag miss", PC_C, 32'h9000, 1'b0, '0, 1'b0, '0);
    step("R9 evicted pc retrains", PC_A, b0 + 3*S2, 1'b0, '0, 1'b0, '0);
    step("R9 retrain 2", PC_A, b0 + 4*S2, 1'b0, '0, 1'b0, '0);
    step("R9 retrain 3", PC_A, b0 + 5*S2, 1'b0, '0, 1'b0, '0);
    step("R9 retrained prefetch", PC_A, b0 + 6*S2, 1'b1, b0 + 7*S2, 1'b1, b0 + 7*S2);
  endtask

  task automatic t_idle();
    step("R11 prefetch before idle", PC_A, b0 + 7*S2, 1'b1, b0 + 8*S2, 1'b1, b0 + 8*S2);
    idle("R10 idle cycle clears valid");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_train();
    t_mismatch();
    t_zero();
    t_negative();
    t_interleave();
    t_conflict();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule